// File: doc/BRIEF.md
# Serial-Programmed Clock Control Register Bank

This block is a two-wire serial slave that holds a small set of byte-wide clock-control registers for a clock synthesizer. It samples SCL and SDA with the system clock and pulls SDA low through an open-drain enable. The register contents are brought out as a flat parallel bus. Register 0 is also decoded into the controls the synthesizer needs: an output-disable flag, spread-spectrum enable, shape and amplitude, and a choice between pin-strapped and software frequency selection.

A write transaction starts with the address byte. Two filler bytes follow: a command byte and a count byte. The slave acknowledges both but does not use their values. After them, data bytes fill register 0, then 1, then 2, with no register addressing. A read transaction starts returning register 0 right after the address acknowledge, and keeps going for as long as the master acknowledges. The register values change only at power-up reset or through a write data byte.

Top module: `clkctl_i2c_regs`

## Requirements
- R1: An address byte whose upper seven bits equal the `DEV_ADDR` parameter (default 7'h69) is acknowledged. Any other address gets no acknowledge, and the slave never drives SDA again until the next START.
- R2: In a write, the first byte after the address is acknowledged and its value changes no register.
- R3: In a write, the second byte after the address is acknowledged and its value changes no register.
- R4: Write data bytes go to register 0, 1, 2 and onward, in arrival order. Each is acknowledged. Register k appears on `reg_flat[8k+7:8k]`.
- R5: A write data byte past the last register (`NUM_REGS`, default 4) is acknowledged and discarded.
- R6: In a read (address bit 0 = 1), the slave sends register 0 MSB first right after the address acknowledge, then the next register after each master ACK. After a master NACK it releases SDA.
- R7: A read past the last register returns 8'hFF.
- R8: All registers are 0 after the power-up reset. START and STOP conditions alone do not change them.
- R9: Register 0 decodes as follows: bit 0 → `out_tristate`, bit 1 → `spread_down` (1 = down spread, 0 = center), bit 2 → `spread_en`, bit 3 → `fsel_from_sw`, bits 6:4 → `fsel_code`, bit 7 → `spread_narrow` (1 = ±0.5%, 0 = ±1.5%).
- R10: A repeated START sends the slave back to the address phase, and the register sequence restarts at register 0.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_flat | output | 8*NUM_REGS | All registers, register k at bits 8k+7:8k |
| out_tristate | output | 1 | Disable all synthesizer outputs |
| spread_down | output | 1 | Down-spread shape selected |
| spread_en | output | 1 | Spread spectrum enabled |
| fsel_from_sw | output | 1 | Frequency code taken from `fsel_code` |
| fsel_code | output | 3 | Software frequency code |
| spread_narrow | output | 1 | Narrow spread amplitude selected |

## Verification
The bench sends different values in the two filler bytes of a write. A slave that treated either filler as data would shift every register by one, or would overwrite register 0 with the filler value. A write of five data bytes, followed by a read of six, tests the register boundary. A design with a pointer that wraps would overwrite or return register 0 where the bench expects the discard or 0xFF. A mismatched address followed by more bytes, and repeated STARTs placed both between and inside transactions, show whether the slave stays silent, and whether it drops a partial sequence instead of carrying its register pointer forward.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_SETUP,
        ST_ACK_HOLD,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } link_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } byte_phase_e;

endpackage

// File: rtl/clkctl_line_sync.sv
module clkctl_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] scl;
        logic [PIPE_W-1:0] sda;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.scl = {pipe_q.scl[PIPE_W-2:0], scl_in};
        pipe_d.sda = {pipe_q.sda[PIPE_W-2:0], sda_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '{scl: '1, sda: '1};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    logic scl_p, sda_p;
    assign scl_s = pipe_q.scl[SYNC_STAGES-1];
    assign sda_s = pipe_q.sda[SYNC_STAGES-1];
    assign scl_p = pipe_q.scl[SYNC_STAGES];
    assign sda_p = pipe_q.sda[SYNC_STAGES];

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/clkctl_link_fsm.sv
module clkctl_link_fsm
    import clkctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int NUM_REGS = 4,
    parameter int PTR_W = $clog2(NUM_REGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [PTR_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

    typedef struct packed {
        link_state_e       state;
        byte_phase_e       phase;
        logic [BYTE_W-1:0] shift;
        logic [2:0]        bit_cnt;
        logic [PTR_W-1:0]  ptr;
        logic              rd_mode;
        logic              m_ack;
        logic              oe;
    } link_t;

    link_t c_q, c_d;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_END) ? p : p + 1'b1;
    endfunction

    logic [BYTE_W-1:0] sh_in;

    always_comb begin
        c_d     = c_q;
        sh_in   = {c_q.shift[BYTE_W-2:0], sda_s};
        wr_en   = 1'b0;
        wr_idx  = c_q.ptr;
        wr_data = sh_in;
        if (start_det) begin
            c_d.state   = ST_RX;
            c_d.phase   = PH_ADDR;
            c_d.bit_cnt = '0;
            c_d.ptr     = '0;
            c_d.rd_mode = 1'b0;
            c_d.oe      = 1'b0;
        end else if (stop_det) begin
            c_d.state = ST_IDLE;
            c_d.oe    = 1'b0;
        end else begin
            unique case (c_q.state)
                ST_RX: if (scl_rise) begin
                    c_d.shift   = sh_in;
                    c_d.bit_cnt = c_q.bit_cnt + 1'b1;
                    if (c_q.bit_cnt == 3'd7) begin
                        c_d.state = ST_ACK_SETUP;
                        if (c_q.phase == PH_ADDR) begin
                            if (sh_in[7:1] == DEV_ADDR) begin
                                c_d.rd_mode = sh_in[0];
                            end else begin
                                c_d.state = ST_IGNORE;
                            end
                        end else if (c_q.phase == PH_DATA) begin
                            wr_en     = 1'b1;
                            c_d.ptr   = bump(c_q.ptr);
                        end
                    end
                end
                ST_ACK_SETUP: if (scl_fall) begin
                    c_d.oe    = 1'b1;
                    c_d.state = ST_ACK_HOLD;
                end
                ST_ACK_HOLD: if (scl_fall) begin
                    c_d.bit_cnt = '0;
                    if (c_q.phase == PH_ADDR && c_q.rd_mode) begin
                        c_d.phase = PH_DATA;
                        c_d.shift = rd_data;
                        c_d.oe    = ~rd_data[7];
                        c_d.ptr   = bump(c_q.ptr);
                        c_d.state = ST_TX;
                    end else begin
                        c_d.oe    = 1'b0;
                        c_d.state = ST_RX;
                        unique case (c_q.phase)
                            PH_ADDR: c_d.phase = PH_CMD;
                            PH_CMD:  c_d.phase = PH_CNT;
                            default: c_d.phase = PH_DATA;
                        endcase
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (c_q.bit_cnt == 3'd7) begin
                        c_d.oe      = 1'b0;
                        c_d.bit_cnt = '0;
                        c_d.state   = ST_TX_ACK;
                    end else begin
                        c_d.bit_cnt = c_q.bit_cnt + 1'b1;
                        c_d.shift   = {c_q.shift[BYTE_W-2:0], 1'b1};
                        c_d.oe      = ~c_q.shift[BYTE_W-2];
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        c_d.m_ack = ~sda_s;
                    end else if (scl_fall) begin
                        if (c_q.m_ack) begin
                            c_d.shift = rd_data;
                            c_d.oe    = ~rd_data[7];
                            c_d.ptr   = bump(c_q.ptr);
                            c_d.state = ST_TX;
                        end else begin
                            c_d.state = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, phase: PH_ADDR, shift: '0, bit_cnt: '0,
                     ptr: '0, rd_mode: 1'b0, m_ack: 1'b0, oe: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_idx = c_q.ptr;
    assign sda_oe = c_q.oe;

    p_oe_rise_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    p_silent_after_mismatch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_IGNORE && !start_det) |=> !sda_oe);

    p_start_to_address_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (c_q.state == ST_RX && c_q.phase == PH_ADDR && c_q.ptr == '0));

    p_stop_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> !sda_oe);

endmodule

// File: rtl/clkctl_reg_bank.sv
module clkctl_reg_bank
    import clkctl_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int PTR_W = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [PTR_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [PTR_W-1:0]           rd_idx,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] reg_flat
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

    logic [BYTE_W-1:0] regs_q [NUM_REGS];
    logic [BYTE_W-1:0] regs_d [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (wr_en && wr_idx < PTR_END) begin
            regs_d[wr_idx[IDX_W-1:0]] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data = (rd_idx < PTR_END) ? regs_q[rd_idx[IDX_W-1:0]] : '1;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign reg_flat[g*BYTE_W +: BYTE_W] = regs_q[g];
    end

    p_hold_without_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_flat));

    p_drop_past_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= PTR_END) |=> $stable(reg_flat));

endmodule

// File: rtl/clkctl_i2c_regs.sv
module clkctl_i2c_regs
    import clkctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int NUM_REGS = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_in,
    input  logic                       sda_in,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] reg_flat,
    output logic                       out_tristate,
    output logic                       spread_down,
    output logic                       spread_en,
    output logic                       fsel_from_sw,
    output logic [2:0]                 fsel_code,
    output logic                       spread_narrow
);
    localparam int PTR_W = $clog2(NUM_REGS + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    logic [BYTE_W-1:0] wr_data, rd_data;

    clkctl_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    clkctl_link_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
    );

    clkctl_reg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .reg_flat(reg_flat)
    );

    assign out_tristate  = reg_flat[0];
    assign spread_down   = reg_flat[1];
    assign spread_en     = reg_flat[2];
    assign fsel_from_sw  = reg_flat[3];
    assign fsel_code     = reg_flat[6:4];
    assign spread_narrow = reg_flat[7];

endmodule

// File: tb/clkctl_i2c_regs_tb.sv
module clkctl_i2c_regs_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [6:0] ADDR = 7'h69;
    localparam int LOW = 8, HIGH = 8, SETUP = 2;
    localparam int WATCHDOG = 150000;

    // {cmd, count, data, expected decode {tri,down,en,sw,fsel[2:0],narrow}}
    localparam int NVEC = 8;
    localparam logic [31:0] VEC [NVEC] = '{
        32'hFF_00_01_80, 32'h00_FF_02_40, 32'h5A_A5_04_20, 32'h01_02_08_10,
        32'h69_69_70_0E, 32'hD2_00_80_01, 32'h33_C4_A6_65, 32'h80_7F_3B_D6
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic m_low = 1'b0;
    logic sda_bus;
    logic sda_oe;
    logic [31:0] reg_flat;
    logic out_tristate, spread_down, spread_en, fsel_from_sw, spread_narrow;
    logic [2:0] fsel_code;

    int checks = 0;
    int failures = 0;
    int hi_toggles = 0;
    int mute_drive = 0;
    logic mute_win = 1'b0;
    logic oe_prev = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign sda_bus = ~(m_low | sda_oe);

    clkctl_i2c_regs #(.DEV_ADDR(ADDR), .NUM_REGS(4), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_oe(sda_oe), .reg_flat(reg_flat), .out_tristate(out_tristate),
        .spread_down(spread_down), .spread_en(spread_en),
        .fsel_from_sw(fsel_from_sw), .fsel_code(fsel_code),
        .spread_narrow(spread_narrow)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_m && sda_oe != oe_prev) hi_toggles++;
            if (mute_win && sda_oe) mute_drive++;
        end
        oe_prev <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_low = 1'b0; wclk(LOW);
        scl_m = 1'b1; wclk(HIGH);
        m_low = 1'b1; wclk(HIGH);
        scl_m = 1'b0; wclk(SETUP);
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; wclk(LOW);
        scl_m = 1'b1; wclk(HIGH);
        m_low = 1'b0; wclk(HIGH);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wclk(LOW - SETUP);
            scl_m = 1'b1; wclk(HIGH);
            scl_m = 1'b0; wclk(SETUP);
        end
        m_low = 1'b0; wclk(LOW - SETUP);
        scl_m = 1'b1; wclk(HIGH / 2);
        acked = (sda_bus == 1'b0);
        wclk(HIGH / 2);
        scl_m = 1'b0; wclk(SETUP);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_low = 1'b0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wclk(LOW - SETUP);
            scl_m = 1'b1; wclk(HIGH / 2);
            b = {b[6:0], sda_bus};
            wclk(HIGH / 2);
            scl_m = 1'b0; wclk(SETUP);
        end
        m_low = give_ack; wclk(LOW - SETUP);
        scl_m = 1'b1; wclk(HIGH);
        scl_m = 1'b0; wclk(SETUP);
        m_low = 1'b0;
    endtask

    task automatic run_tests();
        logic a0, a1, a2, a3;
        logic [7:0] rb;
        logic [31:0] snap;

        wclk(5);
        // R8: power-up state
        check(reg_flat == 32'h0, "R8 reset regs", reg_flat, 32'h0);
        check(sda_oe == 1'b0, "R8 reset sda_oe", {31'b0, sda_oe}, 32'h0);
        rst_n = 1'b1;
        wclk(5);

        // Table walk: filler bytes (R2, R3) and register 0 decode (R9)
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] dec;
            i2c_start();
            send_byte({ADDR, 1'b0}, a0);
            send_byte(VEC[v][31:24], a1);
            send_byte(VEC[v][23:16], a2);
            send_byte(VEC[v][15:8], a3);
            i2c_stop();
            wclk(4);
            check(a0, "R1 address ack", {31'b0, a0}, 32'h1);
            check(a1 && a2, "R2 R3 filler acks", {30'b0, a1, a2}, 32'h3);
            check(reg_flat[7:0] == VEC[v][15:8] && reg_flat[31:8] == 24'h0,
                  "R4 R2 R3 reg0 only", reg_flat, {24'h0, VEC[v][15:8]});
            dec = {out_tristate, spread_down, spread_en, fsel_from_sw, fsel_code,
                   spread_narrow};
            check(dec == VEC[v][7:0], "R9 decode", {24'h0, dec}, {24'h0, VEC[v][7:0]});
        end

        // R4 R5: sequential fill and discard past the end
        i2c_start();
        send_byte({ADDR, 1'b0}, a0);
        send_byte(8'h04, a0);
        send_byte(8'h04, a0);
        send_byte(8'hA1, a0);
        send_byte(8'hB2, a0);
        send_byte(8'hC3, a0);
        send_byte(8'hD4, a0);
        send_byte(8'hE5, a1);
        i2c_stop();
        wclk(4);
        check(reg_flat == 32'hD4C3B2A1, "R4 sequential fill", reg_flat, 32'hD4C3B2A1);
        check(a1, "R5 ack past end", {31'b0, a1}, 32'h1);

        // R8: START/STOP alone change nothing
        i2c_start();
        i2c_stop();
        wclk(4);
        check(reg_flat == 32'hD4C3B2A1, "R8 start-stop no change", reg_flat, 32'hD4C3B2A1);

        // R6 R7: read stream
        i2c_start();
        send_byte({ADDR, 1'b1}, a0);
        check(a0, "R6 read address ack", {31'b0, a0}, 32'h1);
        for (int k = 0; k < 6; k++) begin
            logic [7:0] exp;
            exp = (k < 4) ? reg_flat[k*8 +: 8] : 8'hFF;
            recv_byte(k < 5, rb);
            check(rb == exp, (k < 4) ? "R6 read data" : "R7 read past end",
                  {24'h0, rb}, {24'h0, exp});
        end
        wclk(6);
        check(sda_oe == 1'b0, "R6 released after NACK", {31'b0, sda_oe}, 32'h0);
        i2c_stop();

        // R1: address mismatch, rest ignored
        snap = reg_flat;
        i2c_start();
        send_byte({7'h12, 1'b0}, a0);
        check(!a0, "R1 no ack on mismatch", {31'b0, a0}, 32'h0);
        mute_win = 1'b1;
        send_byte(8'h00, a1);
        send_byte(8'h00, a1);
        send_byte(8'h77, a1);
        mute_win = 1'b0;
        i2c_stop();
        wclk(4);
        check(mute_drive == 0, "R1 silent after mismatch", mute_drive, 0);
        check(reg_flat == snap, "R1 regs unchanged", reg_flat, snap);

        // R10: repeated START to a read
        i2c_start();
        send_byte({ADDR, 1'b0}, a0);
        send_byte(8'h00, a0);
        send_byte(8'h00, a0);
        send_byte(8'h55, a0);
        i2c_start();
        send_byte({ADDR, 1'b1}, a0);
        recv_byte(1'b0, rb);
        i2c_stop();
        check(rb == 8'h55, "R10 restart read reg0", {24'h0, rb}, 32'h55);

        // R10: repeated START inside a write restarts at register 0
        i2c_start();
        send_byte({ADDR, 1'b0}, a0);
        send_byte(8'h11, a0);
        send_byte(8'h22, a0);
        send_byte(8'h66, a0);
        i2c_start();
        send_byte({ADDR, 1'b0}, a0);
        send_byte(8'h33, a0);
        send_byte(8'h44, a0);
        send_byte(8'h77, a0);
        i2c_stop();
        wclk(4);
        check(reg_flat == 32'hD4C3B277, "R10 restart write", reg_flat, 32'hD4C3B277);

        // R11: drive changes only while SCL low
        check(hi_toggles == 0, "R11 SDA stable while SCL high", hi_toggles, 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                wclk(WATCHDOG);
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule